// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Pair with Threshold Flags

This block buffers data words between a host register port and an SPI shift engine. It holds two 16-entry queues. The host fills the transmit queue and the engine drains it. The engine fills the receive queue and the host drains it. A runtime field sets the entry width to one, two, three or four bytes. A three-byte entry is kept in the low 24 bits of a 32-bit slot.

The block reports the fill level of each queue in one status word. It compares the receive level against a programmable threshold. It raises sticky event flags for the empty, full, above-threshold and chip-select-released conditions. Each flag set has an enable register and a write-one-to-clear register, and each direction drives one interrupt line. Writing a flush bit in the configuration word empties either queue at once.

Register addresses are word indices on `reg_addr_i`:
- 0: configuration
- 1: level status
- 2: transmit flags
- 3: transmit enables
- 4: transmit clear
- 5: receive flags
- 6: receive enables
- 7: receive clear
- 8: transmit data push
- 9: receive data pop

Reads of addresses 4, 7 and 8, and of any unmapped address, return zero.

Top module: `spi_xfer_fifo`

## Requirements
- R1: After reset both levels read 0, the enable registers read 0, both interrupts are low, the receive flags read 0, and the transmit flags read 0x2 (empty) from the second cycle on.
- R2: Each queue holds 16 entries and returns words in the order they were written. The level word carries the receive level in bits 12:8 and the transmit level in bits 20:16, with every other bit zero.
- R3: Configuration bits 9:8 hold a width code w. Every word entering either queue keeps its low (w+1) bytes, and the remaining bits are forced to zero. Code 2 keeps bits 23:0 of a 32-bit entry.
- R4: A host write to address 8 while the transmit queue is full is dropped. The level stays at 16, and the dropped word is never presented to the engine.
- R5: A host read of address 9 while the receive queue is empty returns 0 and leaves the level at 0.
- R6: In the configuration word, bit 11 flushes the receive queue and bit 12 flushes the transmit queue. The flushed queue reads level 0 on the next cycle, the other queue is untouched, and both bits read back as 0.
- R7: Transmit flag bits are 0 (queue full), 1 (queue empty) and 6 (chip select released, pulsed on `slave_rel_i`). A flag stays set after its condition ends.
- R8: Receive flag bit 5 sets while the receive level is at least the threshold in configuration bits 3:0, where a threshold of 0 acts as 1. Receive flag bit 6 sets on `slave_rel_i`. Bits 7:4 hold a transmit threshold. Both thresholds and the width code read back.
- R9: Writing a mask to address 4 or 7 clears those flag bits. A bit whose condition still holds is set again on the next cycle.
- R10: `irq_tx_o` and `irq_rx_o` are high exactly when a flag of that direction is set and its bit in the enable register (address 3 or 6, bits 6:0) is set. The enables read back.
- R11: `tx_valid_o` is high while the transmit queue is not empty, and a word leaves on `tx_valid_o && tx_ready_i`. `rx_ready_o` is low while the receive queue is full, and `rx_valid_i` then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the receive queue at address 9) |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the current state |
| tx_valid_o | output | 1 | Transmit word available to the engine |
| tx_ready_i | input | 1 | Engine takes the transmit word |
| tx_data_o | output | 32 | Head of the transmit queue |
| rx_valid_i | input | 1 | Engine offers a received word |
| rx_ready_o | output | 1 | Receive queue can accept a word |
| rx_data_i | input | 32 | Received word |
| slave_rel_i | input | 1 | One-cycle pulse when the engine releases chip select |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rx_o | output | 1 | Receive interrupt |

## Verification
The assertions assume that read and write strobes are never raised together and that `slave_rel_i` is a single-cycle pulse. They also assume the engine may request a pop or push in any cycle and relies on the block to gate it. The stimulus drives at most one strobe per cycle, holds every input for one full clock, and lets the engine's ready and valid inputs arrive on an empty transmit queue or a full receive queue, so that the gating paths behind the overflow and underflow properties are exercised.

// File: rtl/spi_fifo_pkg.sv
`timescale 1ns/1ps
package spi_fifo_pkg;
  localparam int unsigned FIFO_DEPTH = 16;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned FLAG_W     = 7;
  localparam int unsigned THR_W      = 4;
  localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1);

  localparam logic [ADDR_W-1:0] A_CFG   = 4'd0;
  localparam logic [ADDR_W-1:0] A_LVL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_TXFLG = 4'd2;
  localparam logic [ADDR_W-1:0] A_TXEN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_TXCLR = 4'd4;
  localparam logic [ADDR_W-1:0] A_RXFLG = 4'd5;
  localparam logic [ADDR_W-1:0] A_RXEN  = 4'd6;
  localparam logic [ADDR_W-1:0] A_RXCLR = 4'd7;
  localparam logic [ADDR_W-1:0] A_TXDAT = 4'd8;
  localparam logic [ADDR_W-1:0] A_RXDAT = 4'd9;

  localparam int unsigned CFG_RXTHR = 0;
  localparam int unsigned CFG_TXTHR = 4;
  localparam int unsigned CFG_WID   = 8;
  localparam int unsigned CFG_RXFL  = 11;
  localparam int unsigned CFG_TXFL  = 12;
  localparam int unsigned LVL_RX    = 8;
  localparam int unsigned LVL_TX    = 16;

  localparam int unsigned FLG_FULL  = 0;
  localparam int unsigned FLG_EMPTY = 1;
  localparam int unsigned FLG_THR   = 5;
  localparam int unsigned FLG_REL   = 6;

  function automatic logic [DATA_W-1:0] width_mask(logic [1:0] code);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W / 8; b++)
      m[8*b +: 8] = (b <= int'(code)) ? 8'hFF : 8'h00;
    return m;
  endfunction
endpackage

// File: rtl/spi_fifo_buf.sv
`timescale 1ns/1ps
module spi_fifo_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [W-1:0]     rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] count;
  logic             do_push, do_pop;

  assign full_o  = (count == LVL_W'(DEPTH));
  assign empty_o = (count == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign level_o = count;
  assign rdata_o = empty_o ? '0 : mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end

  // R2
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));
  // R6
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> level_o == '0);
  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> level_o == LVL_W'(DEPTH));
  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !flush_i) |=> level_o == '0);
endmodule

// File: rtl/spi_flag_bank.sv
`timescale 1ns/1ps
module spi_flag_bank #(
  parameter int unsigned NF = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] cond_i,
  input  logic [NF-1:0] clr_i,
  input  logic          en_we_i,
  input  logic [NF-1:0] en_wdata_i,
  output logic [NF-1:0] flag_o,
  output logic [NF-1:0] en_o,
  output logic          irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (en_we_i) en_o <= en_wdata_i;
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[i] <= 1'b0;
      else         flag_o[i] <= (flag_o[i] & ~clr_i[i]) | cond_i[i];
    end
    // R7
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
    // R9
    reset_on_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cond_i[i] |=> flag_o[i]);
  end

  assign irq_o = |(flag_o & en_o);
endmodule

// File: rtl/spi_xfer_fifo.sv
`timescale 1ns/1ps
module spi_xfer_fifo
  import spi_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              slave_rel_i,
  output logic              irq_tx_o,
  output logic              irq_rx_o
);
  logic [THR_W-1:0]  rx_thr, tx_thr, rx_thr_eff;
  logic [1:0]        wid;
  logic [DATA_W-1:0] wmask, rx_head;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              cfg_we, rx_pop;
  logic [FLAG_W-1:0] tx_cond, rx_cond, tx_clr, rx_clr;
  logic [FLAG_W-1:0] tx_flag, rx_flag, tx_en, rx_en;

  assign cfg_we = reg_we_i && reg_addr_i == A_CFG;
  assign wmask  = width_mask(wid);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_thr <= '0;
      tx_thr <= '0;
      wid    <= '0;
    end else if (cfg_we) begin
      rx_thr <= reg_wdata_i[CFG_RXTHR +: THR_W];
      tx_thr <= reg_wdata_i[CFG_TXTHR +: THR_W];
      wid    <= reg_wdata_i[CFG_WID +: 2];
    end
  end

  spi_fifo_buf #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i  (reg_we_i && reg_addr_i == A_TXDAT),
    .wdata_i (reg_wdata_i & wmask),
    .pop_i   (tx_ready_i),
    .flush_i (cfg_we && reg_wdata_i[CFG_TXFL]),
    .rdata_o (tx_data_o),
    .level_o (tx_lvl),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  assign rx_pop = reg_re_i && reg_addr_i == A_RXDAT;

  spi_fifo_buf #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i  (rx_valid_i),
    .wdata_i (rx_data_i & wmask),
    .pop_i   (rx_pop),
    .flush_i (cfg_we && reg_wdata_i[CFG_RXFL]),
    .rdata_o (rx_head),
    .level_o (rx_lvl),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign tx_valid_o = ~tx_empty;
  assign rx_ready_o = ~rx_full;

  // a zero threshold behaves as one
  assign rx_thr_eff = (rx_thr == '0) ? THR_W'(1) : rx_thr;

  always_comb begin
    tx_cond = '0;
    tx_cond[FLG_FULL]  = tx_full;
    tx_cond[FLG_EMPTY] = tx_empty;
    tx_cond[FLG_REL]   = slave_rel_i;
    rx_cond = '0;
    rx_cond[FLG_THR]   = rx_lvl >= LVL_W'(rx_thr_eff);
    rx_cond[FLG_REL]   = slave_rel_i;
  end

  assign tx_clr = (reg_we_i && reg_addr_i == A_TXCLR) ? reg_wdata_i[FLAG_W-1:0] : '0;
  assign rx_clr = (reg_we_i && reg_addr_i == A_RXCLR) ? reg_wdata_i[FLAG_W-1:0] : '0;

  spi_flag_bank #(.NF(FLAG_W)) u_tx_flags (
    .clk_i, .rst_ni,
    .cond_i     (tx_cond),
    .clr_i      (tx_clr),
    .en_we_i    (reg_we_i && reg_addr_i == A_TXEN),
    .en_wdata_i (reg_wdata_i[FLAG_W-1:0]),
    .flag_o     (tx_flag),
    .en_o       (tx_en),
    .irq_o      (irq_tx_o)
  );

  spi_flag_bank #(.NF(FLAG_W)) u_rx_flags (
    .clk_i, .rst_ni,
    .cond_i     (rx_cond),
    .clr_i      (rx_clr),
    .en_we_i    (reg_we_i && reg_addr_i == A_RXEN),
    .en_wdata_i (reg_wdata_i[FLAG_W-1:0]),
    .flag_o     (rx_flag),
    .en_o       (rx_en),
    .irq_o      (irq_rx_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CFG: begin
        reg_rdata_o[CFG_RXTHR +: THR_W] = rx_thr;
        reg_rdata_o[CFG_TXTHR +: THR_W] = tx_thr;
        reg_rdata_o[CFG_WID +: 2]       = wid;
      end
      A_LVL: begin
        reg_rdata_o[LVL_RX +: LVL_W] = rx_lvl;
        reg_rdata_o[LVL_TX +: LVL_W] = tx_lvl;
      end
      A_TXFLG: reg_rdata_o[FLAG_W-1:0] = tx_flag;
      A_TXEN:  reg_rdata_o[FLAG_W-1:0] = tx_en;
      A_RXFLG: reg_rdata_o[FLAG_W-1:0] = rx_flag;
      A_RXEN:  reg_rdata_o[FLAG_W-1:0] = rx_en;
      A_RXDAT: reg_rdata_o = rx_head;
      default: reg_rdata_o = '0;
    endcase
  end

  // R11
  rx_full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full && rx_valid_i && !rx_pop && !cfg_we) |=> rx_lvl == LVL_W'(FIFO_DEPTH));
  // R11
  tx_valid_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && !reg_we_i) |=> tx_lvl == $past(tx_lvl) - 1'b1);
  // R10
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en == '0) |-> !irq_tx_o);
endmodule

// File: tb/spi_xfer_fifo_bench.sv
`timescale 1ns/1ps
module spi_xfer_fifo_bench;
  logic        clk = 0, rst_n = 0;
  logic        we = 0, re = 0, tx_ready = 0, rx_valid = 0, rel = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, rx_data = 0;
  logic [31:0] rdata, tx_data;
  logic        tx_valid, rx_ready, irq_tx, irq_rx;

  int n_chk = 0, n_fail = 0;
  logic [31:0] q_tx[$], q_rx[$];
  logic [1:0]  m_w = 0;
  logic [3:0]  m_rxt = 0, m_txt = 0;
  logic [6:0]  m_txf = 0, m_rxf = 0, m_txe = 0, m_rxe = 0;

  always #10 clk = ~clk;

  spi_xfer_fifo u_spi_xfer_fifo (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_data_o(tx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .slave_rel_i(rel), .irq_tx_o(irq_tx), .irq_rx_o(irq_rx));

  function automatic logic [31:0] msk(logic [1:0] w);
    logic [31:0] m = 0;
    for (int b = 0; b <= int'(w); b++) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction
  function automatic logic [6:0] tx_cond();
    return {5'b0, q_tx.size() == 0, q_tx.size() == 16};
  endfunction
  function automatic logic [6:0] rx_cond();
    int t = (m_rxt == 0) ? 1 : int'(m_rxt);
    return {1'b0, q_rx.size() >= t, 5'b0};
  endfunction
  function automatic void upd();
    m_txf |= tx_cond();
    m_rxf |= rx_cond();
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(posedge clk); #1 we = 0;
  endtask
  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(posedge clk); @(negedge clk); addr = a; re = 1;
    #1 d = rdata;
    @(posedge clk); #1 re = 0;
  endtask

  task automatic h_push(logic [31:0] d);
    wr(8, d);
    if (q_tx.size() < 16) q_tx.push_back(d & msk(m_w));
    upd();
  endtask
  task automatic h_pop(string req);
    logic [31:0] d;
    rd(9, d);
    if (q_rx.size() > 0) chk(req, d, q_rx.pop_front());
    else chk(req, d, 0);
    upd();
  endtask
  task automatic e_drain();
    @(negedge clk); tx_ready = 1;
    #1 chk("R11 tx_valid", {31'b0, tx_valid}, {31'b0, q_tx.size() > 0});
    if (q_tx.size() > 0) chk("R2 tx order", tx_data, q_tx.pop_front());
    @(posedge clk); #1 tx_ready = 0;
    upd();
  endtask
  task automatic e_push(logic [31:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    #1 chk("R11 rx_ready", {31'b0, rx_ready}, {31'b0, q_rx.size() < 16});
    @(posedge clk); #1 rx_valid = 0;
    if (q_rx.size() < 16) q_rx.push_back(d & msk(m_w));
    upd();
  endtask
  task automatic cfg(logic [1:0] w, logic [3:0] rt, logic [3:0] tt, bit frx, bit ftx);
    wr(0, {19'b0, ftx, frx, 1'b0, w, tt, rt});
    m_w = w; m_rxt = rt; m_txt = tt;
    if (frx) q_rx.delete();
    if (ftx) q_tx.delete();
    upd();
  endtask
  task automatic pulse_rel();
    @(negedge clk); rel = 1;
    @(posedge clk); #1 rel = 0;
    m_txf |= 7'h40; m_rxf |= 7'h40;
    upd();
  endtask
  task automatic clr(bit is_rx, logic [6:0] m);
    wr(is_rx ? 7 : 4, {25'b0, m});
    if (is_rx) m_rxf &= ~m; else m_txf &= ~m;
    upd();
  endtask
  task automatic en(bit is_rx, logic [6:0] m);
    wr(is_rx ? 6 : 3, {25'b0, m});
    if (is_rx) m_rxe = m; else m_txe = m;
  endtask
  task automatic chk_lvl(string req);
    logic [31:0] d;
    rd(1, d);
    chk(req, d, {11'b0, 5'(q_tx.size()), 3'b0, 5'(q_rx.size()), 8'b0});
  endtask
  task automatic chk_flags(string req);
    logic [31:0] d;
    rd(2, d); chk(req, d, {25'b0, m_txf});
    rd(5, d); chk(req, d, {25'b0, m_rxf});
    chk("R10 irq_tx", {31'b0, irq_tx}, {31'b0, |(m_txf & m_txe)});
    chk("R10 irq_rx", {31'b0, irq_rx}, {31'b0, |(m_rxf & m_rxe)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    upd();
    // R1 reset state
    chk_lvl("R1 level");
    chk_flags("R1 flags");
    rd(3, d); chk("R1 tx_en", d, 0);
    rd(6, d); chk("R1 rx_en", d, 0);

    // R2 R4 fill transmit queue past full
    cfg(2'd3, 4'd4, 4'd9, 0, 0);
    rd(0, d); chk("R8 cfg readback", d, 32'h0000_0394);
    for (int i = 0; i < 17; i++) h_push(32'hA000_0000 + i);
    chk_lvl("R4 level at full");
    chk_flags("R7 full flag");
    for (int i = 0; i < 16; i++) e_drain();
    e_drain();
    chk_lvl("R2 drained");

    // R5 read of empty receive queue
    h_pop("R5 empty read");
    chk_lvl("R5 level");

    // R3 width code 2 and 0
    cfg(2'd2, 4'd0, 4'd0, 0, 0);
    h_push(32'hDEAD_BEEF); e_drain();
    e_push(32'h1234_5678); h_pop("R3 rx width2");
    cfg(2'd0, 4'd0, 4'd0, 0, 0);
    e_push(32'hCAFE_F00D); h_pop("R3 rx width0");

    // R8 zero threshold acts as one; R9 clear with condition held
    clr(1, 7'h7F); chk_flags("R9 rx cleared");
    e_push(32'h55); chk_flags("R8 thr0");
    clr(1, 7'h20); chk_flags("R9 reset while held");
    h_pop("R8 pop");
    clr(1, 7'h20); chk_flags("R9 cleared");

    // R7 slave released, R10 enables
    en(0, 7'h40); en(1, 7'h20);
    rd(3, d); chk("R10 tx_en readback", d, 32'h40);
    pulse_rel(); chk_flags("R7 release");
    clr(0, 7'h40); chk_flags("R9 tx clear");

    // R6 flush one queue only; R11 full receive queue
    cfg(2'd3, 4'd12, 4'd0, 0, 0);
    for (int i = 0; i < 17; i++) e_push(32'hB000_0000 + i);
    h_push(32'h1); h_push(32'h2);
    chk_lvl("R11 rx full");
    chk_flags("R8 above thr");
    cfg(2'd3, 4'd12, 4'd0, 1, 0);
    rd(0, d); chk("R6 flush reads zero", d, 32'h0000_030C);
    chk_lvl("R6 rx flushed");
    cfg(2'd3, 4'd12, 4'd0, 0, 1);
    chk_lvl("R6 tx flushed");

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 11);
      case (op)
        0, 1, 2: h_push($urandom());
        3, 4:    e_drain();
        5, 6, 7: e_push($urandom());
        8:       h_pop("R2 rx order");
        9:       chk_lvl("R2 level");
        10: begin
          chk_flags("R7 R8 flags");
          clr($urandom_range(0, 1), 7'($urandom()));
        end
        default: begin
          case ($urandom_range(0, 3))
            0: cfg(2'($urandom()), 4'($urandom()), 4'($urandom()),
                   $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0);
            1: pulse_rel();
            2: en($urandom_range(0, 1), 7'($urandom()));
            default: chk_flags("R10 flags");
          endcase
        end
      endcase
    end
    chk_flags("R9 final");
    chk_lvl("R2 final");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule